// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a set of small control registers for a workstation I/O controller. Each register lives in its own address window, and a separate select line opens each window. Seven registers share the write-data and read-data buses:

- a configuration byte
- a diagnostic byte
- a modem-control byte
- two auxiliary bytes
- a 16-bit LED register
- a 32-bit system-control word

Reads are combinational. Writes take effect at the next rising clock edge.

Several writes have side effects beyond storing data:

- **Auxiliary register 1.** One bit of a write fires a one-cycle terminal-count strobe toward a floppy controller. That bit is never stored.
- **Auxiliary register 2.** It holds a power-off bit and a power-fail status flag. Software cannot write the flag; a write-one command clears it. The flag is set from an external power-fail input when the configuration enables the interrupt.
- **System-control word.** A reset command loads a readable reset-status flag and emits a one-cycle system-reset request.

The power-fail interrupt output is the AND of the status flag and the enable bit. It is formed combinationally from those two stored bits.

Top module: `auxsc_bank`

## Requirements
- R1: `win_sel` is one-hot, with bit 0 for configuration, 1 for diagnostic, 2 for modem, 3 for aux1, 4 for aux2, 5 for LED and 6 for system-control. Only `offset` 0 is a live location. An access at any other offset, or with no select line or several select lines high, reads 0 and changes nothing.
- R2: `acc_size` codes are 0 for one byte, 1 for two bytes and 2 for four bytes. Byte registers need code 0, the LED register needs code 1 and the system-control word needs code 2. A write of any other size is ignored, and a read of any other size returns 0.
- R3: `pwr_irq` is high exactly when aux2 bit 5 (power-fail status) and configuration bit 3 (interrupt enable) are both set. It follows a configuration write in the cycle the written value is stored.
- R4: When `pwrfail_in` differs from its value in the previous cycle, the status bit becomes (`pwrfail_in` AND enable) one cycle later. While `pwrfail_in` is steady, the status bit holds.
- R5: An aux2 write keeps only data bits 0 and 1. Bit 5 cannot be written. Data bit 1 clears the status and is never stored, so the read value is {status at bit 5, power-off at bit 0}.
- R6: An aux2 write whose data bit 0 is set pulses `poweroff_req` high for exactly the one cycle after the write.
- R7: An aux1 write stores data bits 7:0 with bit 1 forced to 0. If data bit 1 is set, `tc_pulse` is high for exactly the one cycle after the write.
- R8: A system-control write with data bit 0 set loads the word with 0x00000002 and pulses `sysreset_req` for the one cycle after the write. A write with bit 0 clear changes nothing.
- R9: Reset (`rst_n` low at a clock edge) clears configuration, aux1, aux2 (both bits) and modem. Diagnostic, LED and system-control keep their values.
- R10: Configuration, diagnostic and modem store and read back all 8 bits. The LED register stores and reads back all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_sel | input | 7 | One-hot register window select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| acc_size | input | 2 | Access size code |
| offset | input | 2 | Byte offset inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| pwrfail_in | input | 1 | Power-fail indication |
| pwr_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count strobe |
| poweroff_req | output | 1 | Power-off request pulse |
| sysreset_req | output | 1 | System-reset request pulse |

## Verification
The assertions take these inputs as given:

- At most one `win_sel` line is high in any cycle.
- `pwrfail_in` changes only between clock edges.
- The system-control word is first read only after a reset command has loaded it, because it has no reset value.

The stimulus changes every input at the falling clock edge, drives one window at a time, and issues a reset command before any read of the system-control word. Pulse outputs and `pwr_irq` are sampled at the falling edge that follows the write or input change.

// File: rtl/auxsc_pkg.sv
// Shared constants for the auxiliary system control bank: window indices,
// access-size codes and the bit positions that carry side effects.
package auxsc_pkg;
    localparam int NUM_WIN = 7;
    localparam int BYTE_W  = 8;
    localparam int LED_W   = 16;
    localparam int SYS_W   = 32;

    localparam int W_CFG   = 0;
    localparam int W_DIAG  = 1;
    localparam int W_MODEM = 2;
    localparam int W_AUX1  = 3;
    localparam int W_AUX2  = 4;
    localparam int W_LED   = 5;
    localparam int W_SYS   = 6;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int CFG_IRQ_EN_BIT = 3;
    localparam int AUX1_TC_BIT    = 1;
    localparam int AUX2_OFF_BIT   = 0;
    localparam int AUX2_CLR_BIT   = 1;
    localparam int AUX2_PF_BIT    = 5;
    localparam int SYS_CMD_BIT    = 0;
    localparam logic [SYS_W-1:0] SYS_RST_FLAG = 32'h0000_0002;

    // Legal access-size code for each window.
    function automatic logic [1:0] win_size(input int idx);
        if (idx == W_LED)      return SZ_HALF;
        else if (idx == W_SYS) return SZ_WORD;
        else                   return SZ_BYTE;
    endfunction
endpackage

// File: rtl/auxsc_decode.sv
// Access qualifier: turns select, strobe, size and offset into per-window
// write and read hits. Assumes win_sel is one-hot or zero; a multi-hot
// select qualifies nothing.
module auxsc_decode
    import auxsc_pkg::*;
#(
    parameter int N_WIN = NUM_WIN,
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_WIN-1:0] win_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       acc_size,
    input  logic [OFF_W-1:0] offset,
    output logic [N_WIN-1:0] wr_hit,
    output logic [N_WIN-1:0] rd_hit
);
    logic sel_single;
    logic at_base;

    // At most one window may be open and only the base offset is live.
    always_comb begin
        sel_single = ((win_sel & (win_sel - 1'b1)) == '0);
        at_base    = (offset == '0);
    end

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        localparam logic [1:0] LEGAL = win_size(i);
        logic ok;
        // Per-window qualification of size, offset and select.
        always_comb begin
            ok        = win_sel[i] && sel_single && at_base && (acc_size == LEGAL);
            wr_hit[i] = ok && wr_en;
            rd_hit[i] = ok && rd_en;
        end
    end

    a_r1_one_write_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));
endmodule

// File: rtl/auxsc_plain_reg.sv
// Plain storage register with no side effects. CLEARED selects whether a
// block reset zeroes it or leaves its contents alone.
module auxsc_plain_reg #(
    parameter int WIDTH   = 8,
    parameter bit CLEARED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_r;

    if (CLEARED) begin : g_clr
        // Load on write, zero on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)  q_r <= '0;
            else if (we) q_r <= wdata;
        end
    end else begin : g_keep
        // Load on write; reset leaves contents untouched.
        always_ff @(posedge clk) begin
            if (we) q_r <= wdata;
        end
    end

    assign q = q_r;

    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/auxsc_tc_reg.sv
// Auxiliary register 1: stores a byte with the terminal-count bit masked out
// and turns that bit into a one-cycle registered strobe.
module auxsc_tc_reg
    import auxsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] q,
    output logic              tc_pulse
);
    localparam logic [BYTE_W-1:0] TC_MASK = BYTE_W'(1) << AUX1_TC_BIT;

    logic [BYTE_W-1:0] q_r;
    logic              tc_r;

    // Storage without the strobe bit.
    always_ff @(posedge clk) begin
        if (!rst_n)  q_r <= '0;
        else if (we) q_r <= wdata & ~TC_MASK;
    end

    // One-cycle strobe in the cycle after a qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_r <= 1'b0;
        else        tc_r <= we && wdata[AUX1_TC_BIT];
    end

    assign q        = q_r;
    assign tc_pulse = tc_r;

    a_r7_tc_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(we) && $past(wdata[AUX1_TC_BIT]));
    a_r7_tc_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> !q[AUX1_TC_BIT]);
endmodule

// File: rtl/auxsc_pwr_ctl.sv
// Auxiliary register 2 and power-fail logic: keeps the power-off bit, a
// sticky power-fail status updated on input changes, the interrupt output
// and the power-off request pulse. Assumes pwrfail_in is synchronous.
module auxsc_pwr_ctl
    import auxsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              pwrfail_in,
    input  logic              irq_en,
    output logic [BYTE_W-1:0] q,
    output logic              irq,
    output logic              poweroff_req
);
    logic pf_prev;
    logic status;
    logic status_nx;
    logic off_q;
    logic off_req_r;

    // Status next state: re-evaluate on input change, clear on command.
    always_comb begin
        status_nx = status;
        if (pwrfail_in != pf_prev)
            status_nx = pwrfail_in && irq_en;
        if (we && wdata[AUX2_CLR_BIT])
            status_nx = 1'b0;
    end

    // Status, input history and power-off bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_prev <= 1'b0;
            status  <= 1'b0;
            off_q   <= 1'b0;
        end else begin
            pf_prev <= pwrfail_in;
            status  <= status_nx;
            if (we) off_q <= wdata[AUX2_OFF_BIT];
        end
    end

    // One-cycle power-off request after a write storing the off bit.
    always_ff @(posedge clk) begin
        if (!rst_n) off_req_r <= 1'b0;
        else        off_req_r <= we && wdata[AUX2_OFF_BIT];
    end

    // Read image and interrupt.
    always_comb begin
        q               = '0;
        q[AUX2_PF_BIT]  = status;
        q[AUX2_OFF_BIT] = off_q;
        irq             = status && irq_en;
    end

    assign poweroff_req = off_req_r;

    a_r4_status_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(pwrfail_in) && $past(irq_en));
    a_r5_clear_command: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) && $past(wdata[AUX2_CLR_BIT]) |-> !status);
    a_r6_poweroff_stored: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff_req |-> q[AUX2_OFF_BIT]);
endmodule

// File: rtl/auxsc_sys_word.sv
// System-control word: a reset command loads the reset-status flag and emits
// a one-cycle reset request. The word is not cleared by block reset.
module auxsc_sys_word
    import auxsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SYS_W-1:0] wdata,
    output logic [SYS_W-1:0] q,
    output logic             reset_req
);
    logic [SYS_W-1:0] q_r;
    logic             req_r;

    // Load the status flag on a reset command only.
    always_ff @(posedge clk) begin
        if (we && wdata[SYS_CMD_BIT]) q_r <= SYS_RST_FLAG;
    end

    // One-cycle request pulse after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) req_r <= 1'b0;
        else        req_r <= we && wdata[SYS_CMD_BIT];
    end

    assign q         = q_r;
    assign reset_req = req_r;

    a_r8_flag_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (q == SYS_RST_FLAG));
    a_r8_request_from_command: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(we) && $past(wdata[SYS_CMD_BIT]));
endmodule

// File: rtl/auxsc_bank.sv
// Top of the auxiliary system control bank. Instantiates the access decoder
// and the seven registers, and muxes the read data. Assumes one window is
// selected per access and that inputs change away from the clock edge.
module auxsc_bank
    import auxsc_pkg::*;
#(
    parameter int OFF_W  = 2,
    parameter int DATA_W = SYS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] win_sel,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         acc_size,
    input  logic [OFF_W-1:0]   offset,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               pwrfail_in,
    output logic               pwr_irq,
    output logic               tc_pulse,
    output logic               poweroff_req,
    output logic               sysreset_req
);
    logic [NUM_WIN-1:0] wr_hit;
    logic [NUM_WIN-1:0] rd_hit;
    logic [BYTE_W-1:0]  cfg_q, diag_q, modem_q, aux1_q, aux2_q;
    logic [LED_W-1:0]   led_q;
    logic [SYS_W-1:0]   sys_q;
    logic [DATA_W-1:0]  win_val [NUM_WIN];

    auxsc_decode #(.N_WIN(NUM_WIN), .OFF_W(OFF_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .wr_en(wr_en),
        .rd_en(rd_en), .acc_size(acc_size), .offset(offset),
        .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    auxsc_plain_reg #(.WIDTH(BYTE_W), .CLEARED(1'b1)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(wr_hit[W_CFG]),
        .wdata(wdata[BYTE_W-1:0]), .q(cfg_q)
    );
    auxsc_plain_reg #(.WIDTH(BYTE_W), .CLEARED(1'b0)) u_diag (
        .clk(clk), .rst_n(rst_n), .we(wr_hit[W_DIAG]),
        .wdata(wdata[BYTE_W-1:0]), .q(diag_q)
    );
    auxsc_plain_reg #(.WIDTH(BYTE_W), .CLEARED(1'b1)) u_modem (
        .clk(clk), .rst_n(rst_n), .we(wr_hit[W_MODEM]),
        .wdata(wdata[BYTE_W-1:0]), .q(modem_q)
    );
    auxsc_plain_reg #(.WIDTH(LED_W), .CLEARED(1'b0)) u_led (
        .clk(clk), .rst_n(rst_n), .we(wr_hit[W_LED]),
        .wdata(wdata[LED_W-1:0]), .q(led_q)
    );

    auxsc_tc_reg u_aux1 (
        .clk(clk), .rst_n(rst_n), .we(wr_hit[W_AUX1]),
        .wdata(wdata[BYTE_W-1:0]), .q(aux1_q), .tc_pulse(tc_pulse)
    );

    auxsc_pwr_ctl u_aux2 (
        .clk(clk), .rst_n(rst_n), .we(wr_hit[W_AUX2]),
        .wdata(wdata[BYTE_W-1:0]), .pwrfail_in(pwrfail_in),
        .irq_en(cfg_q[CFG_IRQ_EN_BIT]), .q(aux2_q), .irq(pwr_irq),
        .poweroff_req(poweroff_req)
    );

    auxsc_sys_word u_sys (
        .clk(clk), .rst_n(rst_n), .we(wr_hit[W_SYS]),
        .wdata(wdata[SYS_W-1:0]), .q(sys_q), .reset_req(sysreset_req)
    );

    // Zero-extended read image of every window.
    always_comb begin
        win_val[W_CFG]   = DATA_W'(cfg_q);
        win_val[W_DIAG]  = DATA_W'(diag_q);
        win_val[W_MODEM] = DATA_W'(modem_q);
        win_val[W_AUX1]  = DATA_W'(aux1_q);
        win_val[W_AUX2]  = DATA_W'(aux2_q);
        win_val[W_LED]   = DATA_W'(led_q);
        win_val[W_SYS]   = DATA_W'(sys_q);
    end

    // AND-OR read mux over the qualified read hits.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++)
            if (rd_hit[i]) rdata = rdata | win_val[i];
    end

    a_r1_select_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_sel));
    a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_irq |-> cfg_q[CFG_IRQ_EN_BIT]);
    a_r3_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_irq |-> aux2_q[AUX2_PF_BIT]);
endmodule

// File: tb/auxsc_bank_tb.sv
`timescale 1ns/1ps
module auxsc_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  win_sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  offset = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwrfail_in = 1'b0;
    logic        pwr_irq, tc_pulse, poweroff_req, sysreset_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    auxsc_bank dut_i (
        .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .wr_en(wr_en),
        .rd_en(rd_en), .acc_size(acc_size), .offset(offset), .wdata(wdata),
        .rdata(rdata), .pwrfail_in(pwrfail_in), .pwr_irq(pwr_irq),
        .tc_pulse(tc_pulse), .poweroff_req(poweroff_req),
        .sysreset_req(sysreset_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] legal_sz(input int w);
        if (w == 5)      return 2'd1;
        else if (w == 6) return 2'd2;
        else             return 2'd0;
    endfunction

    // Write: drive at a falling edge, release at the next; side effects and
    // pulses are visible when the task returns.
    task automatic wr(input int w, input logic [1:0] sz, input logic [1:0] off,
                      input logic [31:0] d);
        @(negedge clk);
        win_sel = 7'(1) << w; wr_en = 1'b1; acc_size = sz; offset = off; wdata = d;
        @(negedge clk);
        win_sel = '0; wr_en = 1'b0; wdata = '0; offset = '0;
    endtask

    task automatic rd(input int w, input logic [1:0] sz, input logic [1:0] off,
                      output logic [31:0] v);
        @(negedge clk);
        win_sel = 7'(1) << w; rd_en = 1'b1; acc_size = sz; offset = off;
        #1 v = rdata;
        win_sel = '0; rd_en = 1'b0; offset = '0;
    endtask

    task automatic pf_set(input logic v);
        @(negedge clk);
        pwrfail_in = v;
        @(negedge clk);
    endtask

    initial begin : wd
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state of the cleared registers and outputs
        rd(0, 2'd0, 2'd0, v); chk("R9 cfg reset", v, 0);
        rd(2, 2'd0, 2'd0, v); chk("R9 modem reset", v, 0);
        rd(3, 2'd0, 2'd0, v); chk("R9 aux1 reset", v, 0);
        rd(4, 2'd0, 2'd0, v); chk("R9 aux2 reset", v, 0);
        chk("R9 outputs idle", {pwr_irq, tc_pulse, poweroff_req, sysreset_req}, 0);

        // R10: exhaustive byte sweeps on plain registers
        for (int w = 0; w < 3; w++)
            for (int d = 0; d < 256; d++) begin
                wr(w, 2'd0, 2'd0, 32'(d) | 32'hFFFF_FF00);
                rd(w, 2'd0, 2'd0, v);
                chk($sformatf("R10 byte win%0d", w), v, 32'(d));
            end
        wr(0, 2'd0, 2'd0, 0);
        // R10: LED patterns
        for (int i = 0; i < 96; i++) begin
            k = 32'((i * 1021 + 7) & 16'hFFFF);
            wr(5, 2'd1, 2'd0, k | 32'hABCD_0000);
            rd(5, 2'd1, 2'd0, v);
            chk("R10 led", v, k);
        end

        // R7: exhaustive aux1 sweep with strobe timing
        for (int d = 0; d < 256; d++) begin
            wr(3, 2'd0, 2'd0, 32'(d));
            chk("R7 tc strobe", 32'(tc_pulse), 32'((d >> 1) & 1));
            rd(3, 2'd0, 2'd0, v);
            chk("R7 aux1 readback", v, 32'(d & 8'hFD));
            chk("R7 tc one cycle", 32'(tc_pulse), 0);
        end

        // R8: command bit clear does nothing, command loads flag and pulses
        wr(6, 2'd2, 2'd0, 32'hFFFF_FFFF);
        chk("R8 reset request", 32'(sysreset_req), 1);
        @(negedge clk);
        chk("R8 request one cycle", 32'(sysreset_req), 0);
        rd(6, 2'd2, 2'd0, v); chk("R8 flag value", v, 32'h2);
        wr(6, 2'd2, 2'd0, 32'hFFFF_FFFE);
        chk("R8 no request without bit0", 32'(sysreset_req), 0);
        rd(6, 2'd2, 2'd0, v); chk("R8 unchanged without bit0", v, 32'h2);

        // R2: every window against every wrong size
        for (int w = 0; w < 7; w++) begin
            k = (w == 5) ? 32'h55AA : ((w == 6) ? 32'h2 : 32'h55);
            if (w < 6) wr(w, legal_sz(w), 2'd0, k);
            if (w == 4) k = 32'h1;
            for (int s = 0; s < 4; s++) begin
                if (2'(s) == legal_sz(w)) continue;
                wr(w, 2'(s), 2'd0, 32'hFFFF_FFFF);
                chk($sformatf("R2 no pulse win%0d size%0d", w, s),
                    {28'd0, tc_pulse, poweroff_req, sysreset_req, pwr_irq}, 0);
                rd(w, 2'(s), 2'd0, v);
                chk($sformatf("R2 bad-size read win%0d size%0d", w, s), v, 0);
                rd(w, legal_sz(w), 2'd0, v);
                chk($sformatf("R2 value kept win%0d size%0d", w, s), v, k);
            end
        end

        // R1: non-zero offsets and multi-hot selects
        for (int o = 1; o < 4; o++) begin
            wr(0, 2'd0, 2'(o), 32'hAA);
            rd(0, 2'd0, 2'(o), v); chk("R1 offset read zero", v, 0);
            rd(0, 2'd0, 2'd0, v); chk("R1 offset write ignored", v, 32'h55);
            wr(6, 2'd2, 2'(o), 32'h1);
            chk("R1 sys offset no request", 32'(sysreset_req), 0);
        end
        @(negedge clk);
        win_sel = 7'b000_0011; rd_en = 1'b1; acc_size = 2'd0;
        #1 chk("R1 multi-select reads zero", rdata, 0);
        win_sel = '0; rd_en = 1'b0;

        // R3, R4, R5, R6: power-fail sequence
        wr(4, 2'd0, 2'd0, 32'h2);
        wr(0, 2'd0, 2'd0, 32'h08);
        pf_set(1'b1);
        chk("R4 status set on rise", 32'(pwr_irq), 1);
        rd(4, 2'd0, 2'd0, v); chk("R4 aux2 status", v, 32'h20);
        wr(4, 2'd0, 2'd0, 32'h01);
        chk("R6 poweroff pulse", 32'(poweroff_req), 1);
        @(negedge clk);
        chk("R6 poweroff one cycle", 32'(poweroff_req), 0);
        rd(4, 2'd0, 2'd0, v); chk("R5 merge status", v, 32'h21);
        wr(4, 2'd0, 2'd0, 32'hFC);
        chk("R6 no pulse without bit0", 32'(poweroff_req), 0);
        rd(4, 2'd0, 2'd0, v); chk("R5 upper bits dropped", v, 32'h20);
        wr(4, 2'd0, 2'd0, 32'h02);
        chk("R5 clear drops irq", 32'(pwr_irq), 0);
        rd(4, 2'd0, 2'd0, v); chk("R5 clear not stored", v, 0);
        repeat (3) @(negedge clk);
        chk("R4 steady input holds", 32'(pwr_irq), 0);
        wr(4, 2'd0, 2'd0, 32'h03);
        rd(4, 2'd0, 2'd0, v); chk("R5 off with clear", v, 32'h01);
        pf_set(1'b0);
        pf_set(1'b1);
        chk("R4 re-set", 32'(pwr_irq), 1);
        wr(0, 2'd0, 2'd0, 32'h00);
        chk("R3 enable off drops irq", 32'(pwr_irq), 0);
        rd(4, 2'd0, 2'd0, v); chk("R3 status stays", v, 32'h21);
        wr(0, 2'd0, 2'd0, 32'h08);
        chk("R3 enable on raises irq", 32'(pwr_irq), 1);
        pf_set(1'b0);
        chk("R4 cleared on fall", 32'(pwr_irq), 0);
        wr(0, 2'd0, 2'd0, 32'h00);
        pf_set(1'b1);
        rd(4, 2'd0, 2'd0, v); chk("R4 no set when disabled", v, 32'h01);
        pf_set(1'b0);

        // R9: block reset keeps diag, LED and sys
        wr(1, 2'd0, 2'd0, 32'h3C);
        wr(5, 2'd1, 2'd0, 32'hBEEF);
        wr(2, 2'd0, 2'd0, 32'h77);
        wr(3, 2'd0, 2'd0, 32'h41);
        wr(0, 2'd0, 2'd0, 32'h08);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(0, 2'd0, 2'd0, v); chk("R9 cfg cleared", v, 0);
        rd(2, 2'd0, 2'd0, v); chk("R9 modem cleared", v, 0);
        rd(3, 2'd0, 2'd0, v); chk("R9 aux1 cleared", v, 0);
        rd(4, 2'd0, 2'd0, v); chk("R9 aux2 cleared", v, 0);
        rd(1, 2'd0, 2'd0, v); chk("R9 diag kept", v, 32'h3C);
        rd(5, 2'd1, 2'd0, v); chk("R9 led kept", v, 32'hBEEF);
        rd(6, 2'd2, 2'd0, v); chk("R9 sys kept", v, 32'h2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule